// File: doc/BRIEF.md
# IDE PIO Cycle Strobe Generator

This block shapes the drive-side signalling for a single programmed-I/O data transfer on an IDE channel. A transfer runs through three phases in strict sequence: address setup, in which the address is valid but no strobe is driven; an active phase, in which the read or the write strobe is asserted; and a recovery phase, in which the strobe is released but the cycle still holds the bus. The length of each phase comes from a pair of timing bytes that belongs to the addressed drive.

The primary channel has a separate setup byte and a separate packed active/recovery byte for each of its two drives. Both drives on the secondary channel share one pair. The lengths are decoded when a request is accepted, so the timing inputs may be rewritten while a transfer is in flight. A busy output holds off new requests, and a one-clock done pulse marks the end of each transfer. A chip-revision input lengthens recovery by one clock on later silicon.

Top module: `ide_pio_strobe`

## Requirements
- R1: The setup phase length is set by bits 7:6 of the selected setup byte. 2'b00 gives 4 clocks, 2'b10 gives 3, 2'b01 gives 2 and 2'b11 gives 5. Bits 5:0 are ignored.
- R2: The active length is the upper nibble of the selected timing byte, where nibble 0 means 16 clocks. An active nibble of 1 gives 2 clocks, because active is never shorter than 2.
- R3: The recovery length is the lower nibble of the selected timing byte, where 0 means 16. When chip_rev is greater than 1, recovery lasts one clock more than this count.
- R4: When the decoded active length is greater than 3 and the recovery nibble is 1, the recovery count becomes 2. The extra clock from R3 is added after this adjustment.
- R5: Drive 0 uses setup_pri0/rwtim_pri0 and drive 1 uses setup_pri1/rwtim_pri1. Drives 2 and 3 both use setup_sec/rwtim_sec.
- R6: addr_valid is high on every clock of setup, active and recovery. The strobe is high only during active and is low during setup and recovery.
- R7: A read (req_write=0) pulses rd_stb only, and a write (req_write=1) pulses wr_stb only.
- R8: done is high for exactly one clock: the first clock after recovery ends, when busy is already low.
- R9: A request is accepted on a clock edge where busy is low, and busy is high from the next clock on. A request made while busy is high is dropped. It starts no later transfer and does not change the current one.
- R10: While rst is high, and on the clock after rst is sampled high, busy, addr_valid, rd_stb, wr_stb and done are all low. This holds even if rst arrives during a transfer.
- R11: The phase lengths are captured when the request is accepted. Changes to the timing bytes or to chip_rev during a transfer have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request |
| req_drive | input | 2 | Drive index 0..3 |
| req_write | input | 1 | 1 = write, 0 = read |
| setup_pri0 | input | 8 | Setup byte, drive 0 |
| rwtim_pri0 | input | 8 | Active/recovery byte, drive 0 |
| setup_pri1 | input | 8 | Setup byte, drive 1 |
| rwtim_pri1 | input | 8 | Active/recovery byte, drive 1 |
| setup_sec | input | 8 | Shared setup byte, drives 2 and 3 |
| rwtim_sec | input | 8 | Shared active/recovery byte, drives 2 and 3 |
| chip_rev | input | 2 | Chip revision field |
| busy | output | 1 | Transfer in progress |
| addr_valid | output | 1 | Address valid for the whole cycle |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| done | output | 1 | One-clock end-of-transfer pulse |

## Verification
The bench measures each phase length at the ports. It concentrates on the encodings where zero means sixteen, the 1-to-2 active minimum, and the recovery bump that applies only above an active length of 3. A decoder that got these wrong would produce 0- or 1-clock phases, or a recovery that is one clock off.

Unselected timing sets are loaded with decoy values, so a design that routed drive 3 to a primary set, or drive 2 to a private set, would show the wrong lengths. A revision-field test catches a recovery extension applied at the wrong threshold.

The bench also rewrites the timing bytes and chip_rev part-way through a transfer, and pulses req during the active phase. A design that re-read its timing inputs live would stretch or shorten that transfer. A design that queued the request would start a second transfer after the done pulse.

// File: rtl/ide_pio_strobe_pkg.sv
package ide_pio_strobe_pkg;
  localparam int CNT_W = 5;
  localparam int BYTE_W = 8;
  localparam int REV_W = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_t;
endpackage

// File: rtl/pio_timing_select.sv
module pio_timing_select
  import ide_pio_strobe_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int DRV_W = 2,
  parameter int PRI_DRIVES = 2
) (
  input  logic [DRV_W-1:0]  drive,
  input  logic [BYTE_W-1:0] setup_set [NUM_SETS],
  input  logic [BYTE_W-1:0] rwtim_set [NUM_SETS],
  output logic [BYTE_W-1:0] setup_sel,
  output logic [BYTE_W-1:0] rwtim_sel
);
  localparam int SHARED_IDX = NUM_SETS - 1;
  localparam int IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

  logic [IDX_W-1:0] idx;

  // drives below PRI_DRIVES own a set each; all the rest share the last set
  always_comb begin
    if (int'(drive) < PRI_DRIVES) idx = IDX_W'(drive);
    else idx = IDX_W'(SHARED_IDX);
  end

  always_comb begin
    setup_sel = '0;
    rwtim_sel = '0;
    for (int k = 0; k < NUM_SETS; k++) begin
      if (int'(idx) == k) begin
        setup_sel = setup_set[k];
        rwtim_sel = rwtim_set[k];
      end
    end
  end
endmodule

// File: rtl/pio_count_decode.sv
module pio_count_decode
  import ide_pio_strobe_pkg::*;
#(
  parameter int EXT_REV_MIN = 2,
  parameter int ACT_FLOOR = 2,
  parameter int RECOV_BUMP_ABOVE = 3
) (
  input  logic [1:0]        setup_code,
  input  logic [BYTE_W-1:0] rwtim,
  input  logic [REV_W-1:0]  rev,
  output logic [CNT_W-1:0]  setup_len,
  output logic [CNT_W-1:0]  active_len,
  output logic [CNT_W-1:0]  recov_len
);
  logic [3:0]       act_nib, rec_nib;
  logic [CNT_W-1:0] act_raw, rec_raw, rec_adj;

  assign act_nib = rwtim[7:4];
  assign rec_nib = rwtim[3:0];

  always_comb begin
    case (setup_code)
      2'b00:   setup_len = CNT_W'(4);
      2'b10:   setup_len = CNT_W'(3);
      2'b01:   setup_len = CNT_W'(2);
      default: setup_len = CNT_W'(5);
    endcase
  end

  // a zero nibble encodes sixteen clocks
  assign act_raw = (act_nib == 4'd0) ? CNT_W'(16) : CNT_W'(act_nib);
  assign rec_raw = (rec_nib == 4'd0) ? CNT_W'(16) : CNT_W'(rec_nib);

  assign active_len = (act_raw < CNT_W'(ACT_FLOOR)) ? CNT_W'(ACT_FLOOR) : act_raw;

  always_comb begin
    rec_adj = rec_raw;
    if (active_len > CNT_W'(RECOV_BUMP_ABOVE) && rec_raw == CNT_W'(1))
      rec_adj = CNT_W'(2);
    recov_len = (int'(rev) >= EXT_REV_MIN) ? rec_adj + CNT_W'(1) : rec_adj;
  end
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import ide_pio_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_write,
  input  logic [CNT_W-1:0] setup_len,
  input  logic [CNT_W-1:0] active_len,
  input  logic [CNT_W-1:0] recov_len,
  output logic             busy,
  output logic             addr_valid,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             done
);
  phase_t           st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0] act_q, rec_q;
  logic             dir_q, dir_n, done_n, accept;

  assign accept = (st == PH_IDLE) && req;
  assign dir_n  = accept ? req_write : dir_q;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    done_n = 1'b0;
    unique case (st)
      PH_IDLE: if (req) begin
        st_n  = PH_SETUP;
        cnt_n = setup_len - CNT_W'(1);
      end
      PH_SETUP: if (cnt == '0) begin
        st_n  = PH_ACTIVE;
        cnt_n = act_q - CNT_W'(1);
      end else cnt_n = cnt - CNT_W'(1);
      PH_ACTIVE: if (cnt == '0) begin
        st_n  = PH_RECOV;
        cnt_n = rec_q - CNT_W'(1);
      end else cnt_n = cnt - CNT_W'(1);
      PH_RECOV: if (cnt == '0) begin
        st_n   = PH_IDLE;
        done_n = 1'b1;
      end else cnt_n = cnt - CNT_W'(1);
      default: st_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      cnt        <= '0;
      act_q      <= CNT_W'(2);
      rec_q      <= CNT_W'(1);
      dir_q      <= 1'b0;
      busy       <= 1'b0;
      addr_valid <= 1'b0;
      rd_stb     <= 1'b0;
      wr_stb     <= 1'b0;
      done       <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      dir_q <= dir_n;
      if (accept) begin
        act_q <= active_len;
        rec_q <= recov_len;
      end
      busy       <= (st_n != PH_IDLE);
      addr_valid <= (st_n != PH_IDLE);
      rd_stb     <= (st_n == PH_ACTIVE) && !dir_n;
      wr_stb     <= (st_n == PH_ACTIVE) && dir_n;
      done       <= done_n;
    end
  end

  logic any_stb;
  assign any_stb = rd_stb || wr_stb;

  // R6
  stb_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    any_stb |-> (addr_valid && busy));
  // R6
  setup_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(any_stb) |-> $past(addr_valid));
  // R2
  act_floor_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(any_stb) |-> $past(any_stb, 2));
  // R2
  act_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (st != PH_IDLE) |-> (act_q >= CNT_W'(2) && rec_q >= CNT_W'(1)));
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> busy);
  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && $past(any_stb)) |-> $past(rd_stb));
endmodule

// File: rtl/ide_pio_strobe.sv
module ide_pio_strobe
  import ide_pio_strobe_pkg::*;
#(
  parameter int DRV_W = 2,
  parameter int NUM_SETS = 3,
  parameter int PRI_DRIVES = 2,
  parameter int EXT_REV_MIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [DRV_W-1:0] req_drive,
  input  logic             req_write,
  input  logic [7:0]       setup_pri0,
  input  logic [7:0]       rwtim_pri0,
  input  logic [7:0]       setup_pri1,
  input  logic [7:0]       rwtim_pri1,
  input  logic [7:0]       setup_sec,
  input  logic [7:0]       rwtim_sec,
  input  logic [1:0]       chip_rev,
  output logic             busy,
  output logic             addr_valid,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             done
);
  logic [BYTE_W-1:0] setup_set [NUM_SETS];
  logic [BYTE_W-1:0] rwtim_set [NUM_SETS];
  logic [BYTE_W-1:0] setup_sel, rwtim_sel;
  logic [CNT_W-1:0]  s_len, a_len, r_len;
  logic              unused_setup_lo;

  assign setup_set[0] = setup_pri0;
  assign setup_set[1] = setup_pri1;
  assign setup_set[2] = setup_sec;
  assign rwtim_set[0] = rwtim_pri0;
  assign rwtim_set[1] = rwtim_pri1;
  assign rwtim_set[2] = rwtim_sec;

  assign unused_setup_lo = ^setup_sel[5:0];

  pio_timing_select #(
    .NUM_SETS(NUM_SETS), .DRV_W(DRV_W), .PRI_DRIVES(PRI_DRIVES)
  ) u_sel (
    .drive(req_drive), .setup_set(setup_set), .rwtim_set(rwtim_set),
    .setup_sel(setup_sel), .rwtim_sel(rwtim_sel)
  );

  pio_count_decode #(.EXT_REV_MIN(EXT_REV_MIN)) u_dec (
    .setup_code(setup_sel[7:6]), .rwtim(rwtim_sel), .rev(chip_rev),
    .setup_len(s_len), .active_len(a_len), .recov_len(r_len)
  );

  pio_phase_seq u_seq (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write),
    .setup_len(s_len), .active_len(a_len), .recov_len(r_len),
    .busy(busy), .addr_valid(addr_valid), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .done(done)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !(busy || addr_valid || rd_stb || wr_stb || done));
endmodule

// File: tb/sim_ide_pio_strobe.sv
`timescale 1ns/1ps
module sim_ide_pio_strobe;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [1:0] req_drive = '0;
  logic req_write = 1'b0;
  logic [7:0] s_reg [3];
  logic [7:0] t_reg [3];
  logic [1:0] chip_rev = 2'd1;
  logic busy, addr_valid, rd_stb, wr_stb, done;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ide_pio_strobe u0 (
    .clk(clk), .rst(rst), .req(req), .req_drive(req_drive), .req_write(req_write),
    .setup_pri0(s_reg[0]), .rwtim_pri0(t_reg[0]),
    .setup_pri1(s_reg[1]), .rwtim_pri1(t_reg[1]),
    .setup_sec(s_reg[2]), .rwtim_sec(t_reg[2]),
    .chip_rev(chip_rev), .busy(busy), .addr_valid(addr_valid),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done)
  );

  // vector: drive, write, rev, setup byte, timing byte, exp setup, exp active, exp recovery
  localparam int NV = 10;
  localparam logic [35:0] VECS [NV] = '{
    {2'd0, 1'b0, 2'd1, 8'h00, 8'h34, 5'd4, 5'd3, 5'd4},
    {2'd1, 1'b1, 2'd1, 8'h80, 8'h52, 5'd3, 5'd5, 5'd2},
    {2'd2, 1'b0, 2'd2, 8'h40, 8'h23, 5'd2, 5'd2, 5'd4},
    {2'd3, 1'b1, 2'd3, 8'hC0, 8'h00, 5'd5, 5'd16, 5'd17},
    {2'd0, 1'b1, 2'd1, 8'h3F, 8'h11, 5'd4, 5'd2, 5'd1},
    {2'd1, 1'b0, 2'd2, 8'h7F, 8'h41, 5'd2, 5'd4, 5'd3},
    {2'd2, 1'b1, 2'd1, 8'hBF, 8'h41, 5'd3, 5'd4, 5'd2},
    {2'd3, 1'b0, 2'd0, 8'h00, 8'h1F, 5'd4, 5'd2, 5'd15},
    {2'd0, 1'b0, 2'd2, 8'hC0, 8'h31, 5'd5, 5'd3, 5'd2},
    {2'd1, 1'b1, 2'd1, 8'h00, 8'hF0, 5'd4, 5'd15, 5'd16}
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // mode 0 plain, 1 request pulse during active, 2 rewrite timing inputs during setup
  task automatic xfer(input logic [1:0] drv, input logic wr, input logic [1:0] rv,
                      input logic [7:0] sb, input logic [7:0] tb,
                      input int es, input int ea, input int er, input int mode);
    int ns = 0;
    int na = 0;
    int nr = 0;
    int guard = 0;
    bit seen = 0;
    bit bad_av = 0;
    bit bad_dir = 0;
    int sel;
    sel = (drv < 2) ? int'(drv) : 2;
    for (int k = 0; k < 3; k++) begin
      s_reg[k] = ~sb;
      t_reg[k] = tb ^ 8'h77;
    end
    s_reg[sel] = sb;
    t_reg[sel] = tb;
    chip_rev = rv;
    @(negedge clk);
    req = 1'b1; req_drive = drv; req_write = wr;
    @(negedge clk);
    req = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
    while (busy && guard < 80) begin
      guard++;
      if (!addr_valid) bad_av = 1;
      if ((wr && rd_stb) || (!wr && wr_stb)) bad_dir = 1;
      if (rd_stb || wr_stb) begin na++; seen = 1; end
      else if (!seen) ns++;
      else nr++;
      if (mode == 1 && na == 1) begin
        req = 1'b1; req_drive = drv ^ 2'd1; req_write = ~wr;
      end else req = 1'b0;
      if (mode == 2 && ns == 1) begin
        for (int k = 0; k < 3; k++) begin
          s_reg[k] = ~sb;
          t_reg[k] = tb ^ 8'h77;
        end
        chip_rev = ~rv;
      end
      @(negedge clk);
    end
    req = 1'b0;
    check(!bad_av, "R6 addr_valid through cycle", int'(bad_av), 0);
    check(!bad_dir, "R7 strobe direction", int'(bad_dir), 0);
    check(ns == es, (mode == 2) ? "R11 setup length" : "R1 R5 setup length", ns, es);
    check(na == ea, (mode == 2) ? "R11 active length" : "R2 R5 active length", na, ea);
    check(nr == er, (mode == 2) ? "R11 recovery length" : "R3 R4 R5 recovery length", nr, er);
    check(done == 1'b1, "R8 done after recovery", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done single clock", int'(done), 0);
    if (mode == 1) begin
      for (int k = 0; k < 3; k++) begin
        check(!busy && !addr_valid && !rd_stb && !wr_stb, "R9 request while busy dropped",
              int'(busy), 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin s_reg[k] = 8'h00; t_reg[k] = 8'h00; end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R10 outputs quiet in reset
    check(!(busy || addr_valid || rd_stb || wr_stb || done), "R10 reset outputs",
          int'({busy, addr_valid, rd_stb, wr_stb, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy, "R10 idle after reset", int'(busy), 0);

    for (int v = 0; v < NV; v++) begin
      logic [35:0] w;
      w = VECS[v];
      xfer(w[35:34], w[33], w[32:31], w[30:23], w[22:15],
           int'(w[14:10]), int'(w[9:5]), int'(w[4:0]), 0);
    end

    // R9 request during active phase is dropped
    xfer(2'd0, 1'b1, 2'd1, 8'h80, 8'h63, 3, 6, 3, 1);
    // R11 timing inputs rewritten during setup
    xfer(2'd2, 1'b0, 2'd1, 8'h00, 8'h45, 4, 4, 5, 2);
    // R5 drive 3 reaches the shared set as well
    xfer(2'd3, 1'b1, 2'd1, 8'h40, 8'h45, 2, 4, 5, 0);

    // R10 reset in the middle of a transfer
    s_reg[0] = 8'hC0; t_reg[0] = 8'h88; chip_rev = 2'd1;
    @(negedge clk); req = 1'b1; req_drive = 2'd0; req_write = 1'b0;
    @(negedge clk); req = 1'b0;
    repeat (6) @(negedge clk);
    check(rd_stb == 1'b1, "R6 strobe in active before reset", int'(rd_stb), 1);
    rst = 1'b1;
    @(negedge clk);
    check(!(busy || addr_valid || rd_stb || wr_stb || done), "R10 reset mid transfer",
          int'({busy, addr_valid, rd_stb, wr_stb, done}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !done, "R10 stays idle after reset", int'(busy), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule